// File: doc/BRIEF.md
# Parallel Port Byte FIFO with Service Interrupt

This block is a sixteen-entry byte queue between the host side of a parallel port controller and its data pins. The host pushes bytes, and pops them in every mode except the automatic output mode. The block reports when the queue is full and when it is empty. It raises a one-cycle service interrupt when the fill level calls for host attention. Which fill level counts depends on the port direction: in the forward direction it is enough free space, and in the reverse direction it is enough stored bytes.

In the automatic output mode (mode code 3'b010) a sequencer empties the queue onto the pins by itself. It waits until the peripheral is not busy, drives the oldest byte, pulses the active-low strobe for a fixed number of clocks, and then retires the byte. In the test mode (3'b110) and in the extended mode (3'b011) the host may both write and read the queue, and the pins are not touched. A separate registered output carries the error interrupt. A select bit chooses whether that interrupt follows the fault line or the acknowledge line.

Top module: `ppf_top`

## Requirements
- R1: After reset the block shows empty_o=1, full_o=0, svc_o=1, svc_irq_o=0, err_irq_o=0, strobe_n_o=1 and pd_o=0.
- R2: empty_o is 1 exactly when 0 bytes are stored and full_o is 1 exactly when 16 are stored. Both flags follow a push or pop at the next rising edge and are never 1 together.
- R3: rd_data_o shows the oldest stored byte, and bytes leave in the order they were written. A host pop (rd_en_i=1) is accepted in every mode except 3'b010 and only while the output sequencer is idle.
- R4: A push while full and a pop while empty are ignored: the stored contents and the count are unchanged.
- R5: With dir_i=0 and svc_o=0, when at least 4 locations are free at a rising edge, that edge sets svc_o to 1 and pulses svc_irq_o high for exactly one cycle.
- R6: With dir_i=1 and svc_o=0, when at least 12 bytes are stored at a rising edge, that edge sets svc_o to 1 and pulses svc_irq_o for one cycle.
- R7: A host write (svc_wr_i=1) loads svc_val_i into svc_o at the next edge, and an interrupt is suppressed in that cycle. Writing 1 never pulses svc_irq_o. Writing 0 re-arms the interrupt.
- R8: In mode 3'b010, when the queue is not empty and busy_i=0 at an idle edge, pd_o takes the oldest byte at that edge. strobe_n_o goes low at the next edge and stays low for STB_CYCLES cycles. The byte is removed at the edge where strobe_n_o returns high.
- R9: While busy_i=1 no new output transfer starts: strobe_n_o stays 1 and the queue keeps its bytes.
- R10: In any mode other than 3'b010, strobe_n_o stays 1 and pd_o keeps its value while the host writes and reads the queue.
- R11: err_irq_o becomes, one edge later, the inverse of fault_n_i when err_src_i=0, and the inverse of ack_n_i when err_src_i=1.

Ports are listed in the order of the module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Port mode: 3'b010 automatic output, 3'b011 extended, 3'b110 test |
| dir_i | input | 1 | Direction: 0 forward, 1 reverse |
| wr_en_i | input | 1 | Host push strobe |
| wr_data_i | input | 8 | Byte to push |
| rd_en_i | input | 1 | Host pop strobe |
| rd_data_o | output | 8 | Oldest stored byte |
| svc_wr_i | input | 1 | Host write of the service bit |
| svc_val_i | input | 1 | Value written to the service bit |
| err_src_i | input | 1 | Error interrupt source: 0 fault, 1 acknowledge |
| full_o | output | 1 | 16 bytes stored |
| empty_o | output | 1 | No byte stored |
| svc_o | output | 1 | Service bit (1 means interrupt disarmed) |
| svc_irq_o | output | 1 | One-cycle service interrupt pulse |
| err_irq_o | output | 1 | Error interrupt level |
| busy_i | input | 1 | Peripheral busy, active high |
| ack_n_i | input | 1 | Peripheral acknowledge, active low |
| fault_n_i | input | 1 | Peripheral fault, active low |
| strobe_n_o | output | 1 | Data strobe, active low |
| pd_o | output | 8 | Data driven to the port pins |

## Verification
The flags, the service bit and its interrupt pulse, and the error interrupt all change one rising edge after the input or fill level that causes them. An output transfer starts at an idle edge where busy is low. Its strobe falls one edge later and rises STB_CYCLES edges after that, at the same edge that removes the byte. The bench drives inputs on the falling edge. A behavioural model is advanced on each rising edge from the inputs seen there. Every output is compared with the model on the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/ppf_pkg.sv
package ppf_pkg;
    localparam logic [2:0] MODE_AUTO_OUT = 3'b010;
    localparam logic [2:0] MODE_EXT      = 3'b011;
    localparam logic [2:0] MODE_TEST     = 3'b110;

    typedef enum logic [1:0] {
        DR_IDLE   = 2'd0,
        DR_SETUP  = 2'd1,
        DR_STROBE = 2'd2
    } drain_state_e;
endpackage

// File: rtl/ppf_store.sv
module ppf_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  wdata_i,
    output logic [W-1:0]  head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] count;
    } store_t;

    store_t s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        // full/empty judged on the count before this edge
        do_push = push_i && (s_q.count != CW'(DEPTH));
        do_pop  = pop_i  && (s_q.count != '0);
        if (do_push) s_d.wptr = bump(s_q.wptr);
        if (do_pop)  s_d.rptr = bump(s_q.rptr);
        case ({do_push, do_pop})
            2'b10:   s_d.count = s_q.count + 1'b1;
            2'b01:   s_d.count = s_q.count - 1'b1;
            default: s_d.count = s_q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[s_q.wptr] <= wdata_i;
    end

    assign head_o  = mem_q[s_q.rptr];
    assign count_o = s_q.count;
    assign full_o  = (s_q.count == CW'(DEPTH));
    assign empty_o = (s_q.count == '0);
endmodule

// File: rtl/ppf_svc.sv
module ppf_svc #(
    parameter int DEPTH = 16,
    parameter int WR_TH = 4,
    parameter int RD_TH = 12,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] count_i,
    input  logic          dir_i,
    input  logic          sw_wr_i,
    input  logic          sw_val_i,
    output logic          svc_o,
    output logic          irq_o
);
    typedef struct packed {
        logic svc;
        logic irq;
    } svc_t;

    svc_t v_d, v_q;
    logic cond;

    always_comb begin
        // forward: enough free room; reverse: enough waiting bytes
        cond = dir_i ? (count_i >= CW'(RD_TH))
                     : (count_i <= CW'(DEPTH - WR_TH));
        v_d     = v_q;
        v_d.irq = 1'b0;
        if (sw_wr_i) begin
            v_d.svc = sw_val_i;
        end else if (!v_q.svc && cond) begin
            v_d.svc = 1'b1;
            v_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) v_q <= '{svc: 1'b1, irq: 1'b0};
        else        v_q <= v_d;
    end

    assign svc_o = v_q.svc;
    assign irq_o = v_q.irq;
endmodule

// File: rtl/ppf_drain.sv
module ppf_drain
    import ppf_pkg::*;
#(
    parameter int W   = 8,
    parameter int STB = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_i,
    input  logic         empty_i,
    input  logic [W-1:0] head_i,
    input  logic         busy_i,
    output logic         pop_o,
    output logic         idle_o,
    output logic         strobe_n_o,
    output logic [W-1:0] pd_o
);
    localparam int CNTW = (STB < 2) ? 1 : $clog2(STB);

    typedef struct packed {
        drain_state_e    st;
        logic [CNTW-1:0] cnt;
        logic [W-1:0]    pd;
        logic            stb_n;
    } drain_t;

    drain_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        pop_o = 1'b0;
        case (r_q.st)
            DR_IDLE: begin
                if (mode_i == MODE_AUTO_OUT && !empty_i && !busy_i) begin
                    r_d.pd = head_i;
                    r_d.st = DR_SETUP;
                end
            end
            DR_SETUP: begin
                r_d.stb_n = 1'b0;
                r_d.cnt   = CNTW'(STB - 1);
                r_d.st    = DR_STROBE;
            end
            DR_STROBE: begin
                if (r_q.cnt == '0) begin
                    r_d.stb_n = 1'b1;
                    r_d.st    = DR_IDLE;
                    pop_o     = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: r_d.st = DR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: DR_IDLE, cnt: '0, pd: '0, stb_n: 1'b1};
        else        r_q <= r_d;
    end

    assign idle_o     = (r_q.st == DR_IDLE);
    assign strobe_n_o = r_q.stb_n;
    assign pd_o       = r_q.pd;
endmodule

// File: rtl/ppf_top.sv
module ppf_top
    import ppf_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int W          = 8,
    parameter int WR_TH      = 4,
    parameter int RD_TH      = 12,
    parameter int STB_CYCLES = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode_i,
    input  logic         dir_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_en_i,
    output logic [W-1:0] rd_data_o,
    input  logic         svc_wr_i,
    input  logic         svc_val_i,
    input  logic         err_src_i,
    output logic         full_o,
    output logic         empty_o,
    output logic         svc_o,
    output logic         svc_irq_o,
    output logic         err_irq_o,
    input  logic         busy_i,
    input  logic         ack_n_i,
    input  logic         fault_n_i,
    output logic         strobe_n_o,
    output logic [W-1:0] pd_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] count;
    logic [W-1:0]  head;
    logic          seq_pop, seq_idle, host_pop;
    logic          err_d, err_q;

    assign host_pop = rd_en_i && (mode_i != MODE_AUTO_OUT) && seq_idle;

    ppf_store #(.DEPTH(DEPTH), .W(W), .CW(CW)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (wr_en_i),
        .pop_i   (host_pop | seq_pop),
        .wdata_i (wr_data_i),
        .head_o  (head),
        .count_o (count),
        .full_o  (full_o),
        .empty_o (empty_o)
    );

    ppf_svc #(.DEPTH(DEPTH), .WR_TH(WR_TH), .RD_TH(RD_TH), .CW(CW)) svc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_i  (count),
        .dir_i    (dir_i),
        .sw_wr_i  (svc_wr_i),
        .sw_val_i (svc_val_i),
        .svc_o    (svc_o),
        .irq_o    (svc_irq_o)
    );

    ppf_drain #(.W(W), .STB(STB_CYCLES)) drain_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .empty_i    (empty_o),
        .head_i     (head),
        .busy_i     (busy_i),
        .pop_o      (seq_pop),
        .idle_o     (seq_idle),
        .strobe_n_o (strobe_n_o),
        .pd_o       (pd_o)
    );

    always_comb begin
        err_d = err_src_i ? !ack_n_i : !fault_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign err_irq_o = err_q;
    assign rd_data_o = head;
endmodule

// File: rtl/ppf_chk.sv
module ppf_chk #(
    parameter int STB = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode,
    input logic       full,
    input logic       empty,
    input logic       svc,
    input logic       irq,
    input logic       sw_wr,
    input logic       sw_val,
    input logic       strobe_n
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        low_cnt <= '0;
        else if (!strobe_n) low_cnt <= low_cnt + 1'b1;
        else               low_cnt <= '0;
    end

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty)); // R2

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq); // R5

    AST_SVC_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(svc) |-> (irq || $past(sw_wr && sw_val))); // R7

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_n) |-> (low_cnt == 16'(STB))); // R8

    AST_STROBE_NEEDS_OUT_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> ($past(mode, 2) == 3'b010)); // R10
endmodule

bind ppf_top ppf_chk #(.STB(STB_CYCLES)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_i),
    .full     (full_o),
    .empty    (empty_o),
    .svc      (svc_o),
    .irq      (svc_irq_o),
    .sw_wr    (svc_wr_i),
    .sw_val   (svc_val_i),
    .strobe_n (strobe_n_o)
);

// File: tb/ppf_top_tb_top.sv
module ppf_top_tb_top;
    localparam int DEPTH = 16;
    localparam int STB   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_i = 3'b110;
    logic       dir_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       svc_wr_i = 1'b0, svc_val_i = 1'b0, err_src_i = 1'b0;
    logic       busy_i = 1'b0, ack_n_i = 1'b1, fault_n_i = 1'b1;
    logic [7:0] rd_data_o, pd_o;
    logic       full_o, empty_o, svc_o, svc_irq_o, err_irq_o, strobe_n_o;

    always #4 clk = ~clk;

    ppf_top #(.DEPTH(DEPTH), .STB_CYCLES(STB)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .dir_i(dir_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .rd_en_i(rd_en_i),
        .rd_data_o(rd_data_o), .svc_wr_i(svc_wr_i), .svc_val_i(svc_val_i),
        .err_src_i(err_src_i), .full_o(full_o), .empty_o(empty_o),
        .svc_o(svc_o), .svc_irq_o(svc_irq_o), .err_irq_o(err_irq_o),
        .busy_i(busy_i), .ack_n_i(ack_n_i), .fault_n_i(fault_n_i),
        .strobe_n_o(strobe_n_o), .pd_o(pd_o)
    );

    // behavioural reference
    byte unsigned q[$];
    int  phase, left;
    bit  m_svc, m_irq, m_stb_n, m_err;
    byte unsigned m_pd;

    int checks = 0, errors = 0;
    string cur = "R1";
    bit done = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete(); phase = 0; left = 0;
            m_svc = 1; m_irq = 0; m_stb_n = 1; m_err = 0; m_pd = 0;
        end else begin
            int  sz;
            int  ph;
            bit  seq_pop, host_pop, cond;
            sz = q.size(); ph = phase; seq_pop = 0;
            cond = dir_i ? (sz >= 12) : ((DEPTH - sz) >= 4);
            if (ph == 0) begin
                if (mode_i == 3'b010 && sz > 0 && !busy_i) begin
                    m_pd = q[0]; phase = 1;
                end
            end else if (ph == 1) begin
                m_stb_n = 0; left = STB - 1; phase = 2;
            end else begin
                if (left == 0) begin
                    m_stb_n = 1; seq_pop = 1; phase = 0;
                end else left--;
            end
            host_pop = rd_en_i && mode_i != 3'b010 && ph == 0 && sz > 0;
            if (seq_pop || host_pop) void'(q.pop_front());
            if (wr_en_i && sz < DEPTH) q.push_back(wr_data_i);
            m_irq = 0;
            if (svc_wr_i) m_svc = svc_val_i;
            else if (!m_svc && cond) begin m_svc = 1; m_irq = 1; end
            m_err = err_src_i ? !ack_n_i : !fault_n_i;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", cur, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("empty_o", empty_o, q.size() == 0);
            chk("full_o", full_o, q.size() == DEPTH);
            chk("svc_o", svc_o, m_svc);
            chk("svc_irq_o", svc_irq_o, m_irq);
            chk("err_irq_o", err_irq_o, m_err);
            chk("strobe_n_o", strobe_n_o, m_stb_n);
            chk("pd_o", pd_o, m_pd);
            if (q.size() > 0) chk("rd_data_o", rd_data_o, q[0]);
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input logic [7:0] b);
        wr_en_i = 1; wr_data_i = b; tick(); wr_en_i = 0;
    endtask

    task automatic pop(input int n);
        rd_en_i = 1; tick(n); rd_en_i = 0;
    endtask

    task automatic svc_write(input logic v);
        svc_wr_i = 1; svc_val_i = v; tick(); svc_wr_i = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        cur = "R1";
        tick(3); rst_n = 1; tick(3);

        cur = "R2";
        mode_i = 3'b110; dir_i = 0;
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 3));
        tick(2);
        cur = "R4";
        push(8'hEE); push(8'hEF); tick(2);
        cur = "R3";
        pop(16);
        cur = "R4";
        pop(3); tick(2);

        cur = "R5";
        svc_write(0); tick(3);
        for (int i = 0; i < 13; i++) push(8'(8'h40 + i));
        svc_write(0); tick(3);
        pop(1); tick(3);

        cur = "R6";
        pop(12); dir_i = 1; tick();
        svc_write(0); tick(2);
        for (int i = 0; i < 12; i++) push(8'(8'h80 + i));
        tick(3);
        for (int i = 0; i < 5; i++) push(8'(8'hC0 + i));

        cur = "R7";
        svc_write(1); tick(3);
        svc_write(0); tick(3);
        svc_wr_i = 1; svc_val_i = 0; tick(3); svc_wr_i = 0; tick(2);

        cur = "R3";
        pop(16); dir_i = 0; tick(2);

        cur = "R9";
        mode_i = 3'b010; busy_i = 1;
        push(8'h5A); push(8'hA5); push(8'h3C);
        tick(10);

        cur = "R8";
        busy_i = 0; rd_en_i = 1; tick(6); rd_en_i = 0;
        tick(24);
        push(8'h11); push(8'h22); tick(2);
        busy_i = 1; tick(12); busy_i = 0; tick(20);

        cur = "R10";
        mode_i = 3'b011;
        push(8'h77); push(8'h66); pop(1); tick(4);
        mode_i = 3'b110;
        push(8'h55); tick(4); pop(3); tick(3);

        cur = "R11";
        fault_n_i = 0; tick(3);
        fault_n_i = 1; ack_n_i = 0; tick(3);
        err_src_i = 1; tick(3);
        ack_n_i = 1; tick(2);
        fault_n_i = 0; tick(2); fault_n_i = 1; err_src_i = 0; tick(2);

        cur = "R3";
        mode_i = 3'b110;
        for (int i = 0; i < 400; i++) begin
            wr_en_i   = ($urandom % 3) != 0;
            wr_data_i = 8'($urandom);
            rd_en_i   = ($urandom % 2) != 0;
            dir_i     = ($urandom % 5) == 0;
            svc_wr_i  = ($urandom % 9) == 0;
            svc_val_i = ($urandom % 2) != 0;
            tick();
        end
        wr_en_i = 0; rd_en_i = 0; svc_wr_i = 0;
        tick(4);
        finish_run();
    end
endmodule